// File: doc/BRIEF.md
# ATM Header Error Check Verifier

This block screens the five-byte header of every received ATM cell. Bytes one to four are protected by an eight-bit check byte in the fifth position. The block recomputes that check, derives a syndrome, and decides for each cell whether to pass it unchanged, pass it with one flipped bit repaired, or mark it for discard. It is meant to sit right after cell delineation in a receive path. Downstream logic stores a cell only when the discard flag is low.

The decision depends on a two-state engine. In correction mode a single-bit error is repaired, and in detection mode any error leads to a discard. Any errored cell moves the engine into detection mode. It returns to correction mode only after a run of consecutive clean cells whose length is set by a two-bit threshold code. A correction-enable input can hold the engine in detection mode indefinitely. All results are registered and appear one clock after the cell is presented.

Top module: `atm_hec_verifier`

## Requirements
- R1: Synchronous active-high reset clears `out_vld`, `drop`, `fix_pulse` and `bad_pulse`, and leaves the engine in correction mode with a zero clean-cell count. A single-bit error in the first cell after reset is therefore repaired.
- R2: The expected check byte is the CRC-8 of header bytes one to four, XORed with 8'h55. The CRC uses generator x^8+x^2+x+1, a zero initial value, and the most significant bit of byte one first. Byte one is on `hdr_in[39:32]` and the check byte is on `hdr_in[7:0]`. A cell whose check byte matches this value leaves the block unchanged, with `drop`, `fix_pulse` and `bad_pulse` low.
- R3: Each cycle with `cell_vld` high produces exactly one cycle of `out_vld` on the following clock, together with that cell's results. Cells may arrive back to back. `out_vld` stays low in every other cycle.
- R4: In correction mode, a syndrome that matches an error in any one of the 40 header bits causes that bit to be inverted on `hdr_out`. The cell is passed with `fix_pulse` high, and the engine enters detection mode.
- R5: In correction mode, a nonzero syndrome that matches no single-bit error raises `drop` and `bad_pulse`, and the engine enters detection mode.
- R6: In detection mode, any cell with a nonzero syndrome raises `drop` and `bad_pulse` and clears the clean-cell count to zero.
- R7: In detection mode, each clean cell increments the count. When the count reaches M, the engine returns to correction mode and the count is cleared. The threshold code sets M as follows: 00 gives 0, 01 gives 1, 10 gives 3, and 11 gives 7. A cell arriving before M consecutive clean cells have been seen is treated in detection mode.
- R8: With threshold code 00 and correction enabled, the engine always behaves as in correction mode. Every single-bit error is repaired, even in consecutive cells.
- R9: While `corr_en` is low, no cell is repaired and single-bit errors are dropped with `bad_pulse`, whatever the threshold code. The engine is held in detection mode with a zero count, so after `corr_en` rises it still needs M clean cells before it repairs again.
- R10: `fix_pulse` and `bad_pulse` are never high together. Neither they nor `drop` is ever high without `out_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_vld | input | 1 | Header on `hdr_in` is valid this cycle |
| hdr_in | input | 40 | Received header, byte one in the top byte, check byte in the bottom byte |
| corr_en | input | 1 | Allows correction mode when high |
| thresh_code | input | 2 | Selects the clean-cell count M needed to leave detection mode |
| out_vld | output | 1 | Results for one cell are valid |
| hdr_out | output | 40 | Header after any single-bit repair |
| drop | output | 1 | Cell must be discarded |
| fix_pulse | output | 1 | A single-bit error was repaired in this cell |
| bad_pulse | output | 1 | An error was found and the cell was not repaired |

## Verification
The assertions assume that `corr_en` and `thresh_code` are stable while a cell is in flight. They also assume that the inputs carry known values after reset, so the decoded threshold and the mode-related invariants are meaningful. The stimulus changes the control inputs only between cells, with no cell pending. Every multi-bit error it injects flips exactly two bits. Because the generator contains the factor x+1, a two-bit error can never alias to a single-bit syndrome, so each injected error falls cleanly into the correctable or the uncorrectable class.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int HDR_W   = 40;
  localparam int DATA_W  = 32;
  localparam int SYN_W   = 8;
  localparam logic [SYN_W-1:0] GEN_POLY = 8'h07;
  localparam logic [SYN_W-1:0] COSET    = 8'h55;

  typedef enum logic {
    MODE_CORR = 1'b0,
    MODE_DET  = 1'b1
  } hec_mode_e;

  // Linear CRC part (no coset), serial MSB-first over the data word.
  function automatic logic [SYN_W-1:0] crc8_calc(input logic [DATA_W-1:0] d);
    logic [SYN_W-1:0] r;
    logic fb;
    r = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = r[SYN_W-1] ^ d[b];
      r  = {r[SYN_W-2:0], 1'b0};
      if (fb) r = r ^ GEN_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output logic [SYN_W-1:0] syn
);
  always_comb begin
    syn = crc8_calc(hdr[HDR_W-1:SYN_W]) ^ COSET ^ hdr[SYN_W-1:0];
  end
endmodule

// File: rtl/hec_locator.sv
module hec_locator
  import hec_pkg::*;
(
  input  logic [SYN_W-1:0] syn,
  output logic [HDR_W-1:0] flip_mask,
  output logic             single
);
  for (genvar i = 0; i < HDR_W; i++) begin : g_pos
    if (i < SYN_W) begin : g_chk
      localparam logic [SYN_W-1:0] PAT = SYN_W'(1) << i;
      assign flip_mask[i] = (syn == PAT);
    end else begin : g_dat
      localparam logic [SYN_W-1:0] PAT = crc8_calc(DATA_W'(1) << (i - SYN_W));
      assign flip_mask[i] = (syn == PAT);
    end
  end

  assign single = |flip_mask;
endmodule

// File: rtl/hec_mode_ctl.sv
module hec_mode_ctl
  import hec_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int THR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_vld,
  input  logic             corr_en,
  input  logic [THR_W-1:0] thresh_code,
  input  logic             syn_zero,
  input  logic             syn_single,
  output logic             do_fix,
  output logic             do_drop,
  output hec_mode_e        mode_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   cnt_inc;
  logic             corr_active;

  always_comb begin
    lim         = (CNT_W'(1) << thresh_code) - CNT_W'(1);
    cnt_inc     = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(1);
    corr_active = corr_en && ((mode_q == MODE_CORR) || (lim == '0));
    do_fix      = cell_vld && corr_active && !syn_zero && syn_single;
    do_drop     = cell_vld && !syn_zero && !do_fix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CORR;
      cnt_q  <= '0;
    end else if (!corr_en) begin
      mode_q <= MODE_DET;
      cnt_q  <= '0;
    end else if (cell_vld) begin
      if (!syn_zero) begin
        mode_q <= MODE_DET;
        cnt_q  <= '0;
      end else if (mode_q == MODE_DET) begin
        if (cnt_inc >= {1'b0, lim}) begin
          mode_q <= MODE_CORR;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/atm_hec_verifier.sv
module atm_hec_verifier
  import hec_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int THR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_vld,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic             corr_en,
  input  logic [THR_W-1:0] thresh_code,
  output logic             out_vld,
  output logic [HDR_W-1:0] hdr_out,
  output logic             drop,
  output logic             fix_pulse,
  output logic             bad_pulse
);
  logic [SYN_W-1:0] syn;
  logic [HDR_W-1:0] flip_mask;
  logic             syn_single;
  logic             do_fix;
  logic             do_drop;
  hec_mode_e        eng_mode;
  logic [CNT_W-1:0] clean_cnt;

  hec_syndrome u_syn (
    .hdr (hdr_in),
    .syn (syn)
  );

  hec_locator u_loc (
    .syn       (syn),
    .flip_mask (flip_mask),
    .single    (syn_single)
  );

  hec_mode_ctl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .cell_vld    (cell_vld),
    .corr_en     (corr_en),
    .thresh_code (thresh_code),
    .syn_zero    (syn == '0),
    .syn_single  (syn_single),
    .do_fix      (do_fix),
    .do_drop     (do_drop),
    .mode_q      (eng_mode),
    .cnt_q       (clean_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      hdr_out   <= '0;
      drop      <= 1'b0;
      fix_pulse <= 1'b0;
      bad_pulse <= 1'b0;
    end else begin
      out_vld   <= cell_vld;
      drop      <= do_drop;
      fix_pulse <= do_fix;
      bad_pulse <= do_drop;
      if (cell_vld) hdr_out <= do_fix ? (hdr_in ^ flip_mask) : hdr_in;
    end
  end
endmodule

// File: rtl/atm_hec_verifier_chk.sv
module atm_hec_verifier_chk
  import hec_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cell_vld,
  input logic             corr_en,
  input logic             out_vld,
  input logic [HDR_W-1:0] hdr_out,
  input logic             drop,
  input logic             fix_pulse,
  input logic             bad_pulse,
  input hec_mode_e        eng_mode,
  input logic [CNT_W-1:0] clean_cnt
);
  // R10
  fix_bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fix_pulse && bad_pulse));

  // R10
  flags_need_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (fix_pulse || bad_pulse || drop) |-> out_vld);

  // R3
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cell_vld |=> out_vld);

  // R3
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !cell_vld |=> !out_vld);

  // R2
  passed_hec_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !drop) |-> (hdr_out[SYN_W-1:0] == (crc8_calc(hdr_out[HDR_W-1:SYN_W]) ^ COSET)));

  // R9
  no_fix_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cell_vld && !corr_en) |=> !fix_pulse);

  // R7
  corr_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_mode == MODE_CORR) |-> (clean_cnt == '0));

  // R7
  cnt_below_max_chk: assert property (@(posedge clk) disable iff (rst)
    clean_cnt != '1);
endmodule

bind atm_hec_verifier atm_hec_verifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cell_vld  (cell_vld),
  .corr_en   (corr_en),
  .out_vld   (out_vld),
  .hdr_out   (hdr_out),
  .drop      (drop),
  .fix_pulse (fix_pulse),
  .bad_pulse (bad_pulse),
  .eng_mode  (eng_mode),
  .clean_cnt (clean_cnt)
);

// File: tb/atm_hec_verifier_bench.sv
module atm_hec_verifier_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_vld = 1'b0;
  logic [39:0] hdr_in = '0;
  logic        corr_en = 1'b1;
  logic [1:0]  thresh_code = 2'b11;
  logic        out_vld;
  logic [39:0] hdr_out;
  logic        drop;
  logic        fix_pulse;
  logic        bad_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  atm_hec_verifier u_atm_hec_verifier (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .hdr_in(hdr_in),
    .corr_en(corr_en), .thresh_code(thresh_code), .out_vld(out_vld),
    .hdr_out(hdr_out), .drop(drop), .fix_pulse(fix_pulse), .bad_pulse(bad_pulse)
  );

  // Bytewise CRC with generator 0x07, zero start, then coset 0x55.
  function automatic logic [7:0] ref_hec(input logic [31:0] d);
    logic [7:0] c = 8'h00;
    for (int k = 3; k >= 0; k--) begin
      c = c ^ d[k*8 +: 8];
      for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [39:0] mk(input logic [31:0] d);
    return {d, ref_hec(d)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Present one cell, then check its registered results one cycle later.
  task automatic send(input logic [39:0] h, input bit exp_drop, input bit exp_fix,
                      input logic [39:0] exp_h, input string req);
    @(negedge clk);
    hdr_in = h; cell_vld = 1'b1;
    @(negedge clk);
    cell_vld = 1'b0; hdr_in = '0;
    chk(out_vld && drop == exp_drop && fix_pulse == exp_fix && bad_pulse == exp_drop,
        req, "flags vld/drop/fix/bad",
        {36'd0, out_vld, drop, fix_pulse, bad_pulse},
        {36'd0, 1'b1, exp_drop, exp_fix, exp_drop});
    if (!exp_drop) chk(hdr_out == exp_h, req, "header", hdr_out, exp_h);
  endtask

  task automatic clean(input int n, input logic [31:0] seed, input string req);
    for (int k = 0; k < n; k++) begin
      logic [39:0] g = mk(seed + 32'(k) * 32'h0101_0307);
      send(g, 1'b0, 1'b0, g, req);
    end
  endtask

  task automatic t_reset;
    logic [39:0] g = mk(32'h0000_0001);
    @(negedge clk);
    chk({out_vld, drop, fix_pulse, bad_pulse} == 4'b0, "R1", "reset outputs",
        {36'd0, out_vld, drop, fix_pulse, bad_pulse}, 40'd0);
    send(g ^ (40'd1 << 20), 1'b0, 1'b1, g, "R1");
  endtask

  task automatic t_clean;
    clean(7, 32'h1111_2222, "R2");
    send(mk(32'h0), 1'b0, 1'b0, mk(32'h0), "R2");
    send(mk(32'hFFFF_FFFF), 1'b0, 1'b0, mk(32'hFFFF_FFFF), "R2");
    send(mk(32'h0000_0010), 1'b0, 1'b0, mk(32'h0000_0010), "R2");
  endtask

  task automatic t_all_bits;
    thresh_code = 2'b00;
    for (int i = 0; i < 40; i++) begin
      logic [39:0] g = mk(32'h1234_5678 + 32'(i) * 32'h0001_0203);
      send(g ^ (40'd1 << i), 1'b0, 1'b1, g, i < 2 ? "R8" : "R4");
    end
  endtask

  task automatic t_enter_det;
    logic [39:0] g = mk(32'hCAFE_0042);
    thresh_code = 2'b11;
    clean(7, 32'h5555_0000, "R7");
    send(g ^ (40'd1 << 33), 1'b0, 1'b1, g, "R4");
    send(g ^ (40'd1 << 3), 1'b1, 1'b0, g, "R4");
    clean(7, 32'h7777_0000, "R7");
    send(g ^ 40'h00_0000_0300, 1'b1, 1'b0, g, "R5");
    send(g ^ (40'd1 << 12), 1'b1, 1'b0, g, "R5");
  endtask

  task automatic t_thresh(input logic [1:0] code, input int m);
    logic [39:0] g = mk(32'hBEEF_0000 | 32'(m));
    thresh_code = code;
    clean(7, 32'h0F0F_0000, "R7");
    send(g ^ 40'h80_0000_0001, 1'b1, 1'b0, g, "R5");
    clean(m - 1, 32'h3030_0000, "R7");
    send(g ^ (40'd1 << 9), 1'b1, 1'b0, g, "R6");
    clean(m - 1, 32'h4040_0000, "R6");
    send(g ^ (40'd1 << 27), 1'b1, 1'b0, g, "R6");
    clean(m, 32'h6060_0000, "R7");
    send(g ^ (40'd1 << 38), 1'b0, 1'b1, g, "R7");
  endtask

  task automatic t_disable;
    logic [39:0] g = mk(32'h0BAD_F00D);
    thresh_code = 2'b00;
    @(negedge clk); corr_en = 1'b0;
    send(g ^ (40'd1 << 15), 1'b1, 1'b0, g, "R9");
    clean(2, 32'h9999_0000, "R9");
    send(g ^ (40'd1 << 0), 1'b1, 1'b0, g, "R9");
    thresh_code = 2'b01;
    @(negedge clk); corr_en = 1'b1;
    send(g ^ (40'd1 << 30), 1'b1, 1'b0, g, "R9");
    clean(1, 32'hABAB_0000, "R9");
    send(g ^ (40'd1 << 30), 1'b0, 1'b1, g, "R9");
  endtask

  task automatic t_stream;
    logic [39:0] a = mk(32'h0102_0304);
    logic [39:0] b = mk(32'hA0B0_C0D0);
    @(negedge clk); hdr_in = a; cell_vld = 1'b1;
    @(negedge clk); hdr_in = b;
    chk(out_vld && !drop && hdr_out == a, "R3", "first of pair", hdr_out, a);
    @(negedge clk); cell_vld = 1'b0; hdr_in = '0;
    chk(out_vld && !drop && hdr_out == b, "R3", "second of pair", hdr_out, b);
    @(negedge clk);
    chk(!out_vld && !fix_pulse && !bad_pulse && !drop, "R3", "idle after pair",
        {36'd0, out_vld, drop, fix_pulse, bad_pulse}, 40'd0);
    @(negedge clk);
    chk(!out_vld, "R10", "idle stays quiet", {39'd0, out_vld}, 40'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_all_bits();
    t_enter_det();
    t_thresh(2'b01, 1);
    t_thresh(2'b10, 3);
    t_thresh(2'b11, 7);
    t_disable();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule